// File: doc/BRIEF.md
# Graphics Command Packet Assembler

This block sits behind the data port of a graphics engine and groups the 32-bit words written there into whole command packets. The top byte of the first word of each packet is the opcode. A fixed per-opcode lookup says how many parameter words must follow it. The block collects the opcode word and its parameters in a twelve-slot buffer. When the packet is complete, it raises a one-cycle dispatch strobe. During that cycle it presents the packet contents, the opcode and the total word count to the execution stage.

Writes to the control port can throw away a half-collected packet. A full-reset command (control top byte 0x00), a command-buffer-reset command (control top byte 0x01), or a control word equal to exactly 0x04000000 abandons any pending packet. The next data word is then taken as a fresh opcode. An opcode whose lookup count is zero forms a packet by itself and is dispatched straight away.

Top module: `cmd_packet_assembler`

## Requirements
- R1: After synchronous active-low reset, `pkt_valid` is low and no packet is pending, so the first accepted data word is treated as an opcode word.
- R2: Parameter counts for opcodes 0x20..0x3F come in groups of four consecutive opcodes. Starting at 0x20, the groups take 3, 6, 4, 8, 5, 8, 7 and 11 parameter words in turn.
- R3: Parameter counts for opcodes 0x40..0x7F come in groups of four. Starting at 0x40, the sixteen groups take 2, 0, 3, 3, 3, 0, 4, 4, 2, 3, 1, 2, 1, 2, 1, 2 words in turn.
- R4: Opcode 0x80 takes 3 parameter words. Opcodes 0x02, 0xA0 and 0xC0 take 2 each. Every other opcode outside 0x20..0x7F takes 0.
- R5: Each packet's words appear on `pkt_words` in arrival order, with word k in bits [32k+31:32k]. `pkt_count` equals 1 plus the parameter count, and `pkt_opcode` equals bits 31..24 of word 0. No strobe occurs before the last word.
- R6: `pkt_valid` rises in the cycle right after the clock edge that accepts the last word of a packet. For a zero-parameter opcode, that last word is the opcode word itself.
- R7: The dispatch strobe lasts exactly one cycle when no further packet completes in that cycle.
- R8: A control write whose top byte is 0x00 or 0x01 abandons a pending packet, and the next data word starts a new packet.
- R9: A control write of exactly 0x04000000 abandons a pending packet. The value 0x04000001 does not, and collection continues.
- R10: An abort in the same cycle as a data word takes priority: the word is dropped and no dispatch results from it.
- R11: Idle cycles (`in_valid` low) between words of a packet neither dispatch nor disturb the packet being collected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A data word is offered this cycle |
| in_word | input | 32 | Data-port word |
| ctl_valid | input | 1 | A control-port word is offered this cycle |
| ctl_word | input | 32 | Control-port word, decoded for abort commands |
| pkt_valid | output | 1 | One-cycle dispatch strobe |
| pkt_opcode | output | 8 | Opcode of the dispatched packet |
| pkt_count | output | 4 | Total words in the dispatched packet (1..12) |
| pkt_words | output | 384 | Packet buffer, word k at bits [32k+31:32k] |

## Verification
Every result is due exactly one cycle after the accepting edge. The strobe, count, opcode and buffer contents all come from the same registers, loaded at the edge that takes the final word. The bench drives each word on a falling edge and lets one rising edge consume it. It samples at the following falling edge, which is the first point where that edge's result can be seen. Between words it expects the strobe low. After the last word it expects it high, and after one more idle step low again. Abort cases are judged the same way: the dropped or abandoned words must never produce a strobe in the cycle after they are offered.

// File: rtl/cpa_pkg.sv
// Shared sizing for the command packet assembler.
// Assumes the longest packet is one opcode word plus eleven parameters.
package cpa_pkg;
    localparam int WORD_W    = 32;
    localparam int OP_W      = 8;
    localparam int MAX_WORDS = 12;
    localparam int CNT_W     = $clog2(MAX_WORDS + 1);
    localparam int IDX_W     = $clog2(MAX_WORDS);

    // Control-port abort encodings
    localparam logic [7:0]        CTL_FULL_RESET = 8'h00;
    localparam logic [7:0]        CTL_CMD_RESET  = 8'h01;
    localparam logic [WORD_W-1:0] CTL_FLUSH_WORD = 32'h0400_0000;
endpackage

// File: rtl/cpa_len_lut.sv
// Opcode to parameter-word-count lookup.
// Pure combinational; opcodes in 0x20..0x7F are grouped by fours.
module cpa_len_lut
    import cpa_pkg::*;
(
    input  logic [OP_W-1:0]  opcode,
    output logic [CNT_W-1:0] param_cnt
);
    // Decode the count from the opcode group or from the few single opcodes
    always_comb begin
        param_cnt = '0;
        case (opcode[7:2])
            6'h08: param_cnt = CNT_W'(3);
            6'h09: param_cnt = CNT_W'(6);
            6'h0A: param_cnt = CNT_W'(4);
            6'h0B: param_cnt = CNT_W'(8);
            6'h0C: param_cnt = CNT_W'(5);
            6'h0D: param_cnt = CNT_W'(8);
            6'h0E: param_cnt = CNT_W'(7);
            6'h0F: param_cnt = CNT_W'(11);
            6'h10: param_cnt = CNT_W'(2);
            6'h12, 6'h13, 6'h14: param_cnt = CNT_W'(3);
            6'h16, 6'h17: param_cnt = CNT_W'(4);
            6'h18, 6'h1B, 6'h1D, 6'h1F: param_cnt = CNT_W'(2);
            6'h19: param_cnt = CNT_W'(3);
            6'h1A, 6'h1C, 6'h1E: param_cnt = CNT_W'(1);
            default: begin
                case (opcode)
                    8'h02, 8'hA0, 8'hC0: param_cnt = CNT_W'(2);
                    8'h80:               param_cnt = CNT_W'(3);
                    default:             param_cnt = '0;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/cpa_ctl_decode.sv
// Control-port decoder producing the packet abort.
// Abort is combinational so it acts in the same cycle as the control write.
module cpa_ctl_decode
    import cpa_pkg::*;
(
    input  logic              ctl_valid,
    input  logic [WORD_W-1:0] ctl_word,
    output logic              abort
);
    // Flag the two reset commands and the exact flush value
    always_comb begin
        abort = ctl_valid &&
                ((ctl_word[31:24] == CTL_FULL_RESET) ||
                 (ctl_word[31:24] == CTL_CMD_RESET)  ||
                 (ctl_word == CTL_FLUSH_WORD));
    end
endmodule

// File: rtl/cpa_collector.sv
// Packet sequencer and word buffer.
// Assumes param_cnt is valid for the opcode in in_word; abort wins over in_valid.
module cpa_collector
    import cpa_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [WORD_W-1:0]           in_word,
    input  logic                        abort,
    input  logic [CNT_W-1:0]            param_cnt,
    output logic                        pkt_valid,
    output logic [OP_W-1:0]             pkt_opcode,
    output logic [CNT_W-1:0]            pkt_count,
    output logic [MAX_WORDS*WORD_W-1:0] pkt_words
);
    logic              busy;
    logic [CNT_W-1:0]  remain;
    logic [IDX_W-1:0]  idx;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [WORD_W-1:0] slot [MAX_WORDS];

    // Select the buffer slot for an accepted word
    always_comb begin
        wr_en  = in_valid && !abort;
        wr_idx = busy ? idx : '0;
    end

    // Track the pending packet and raise the dispatch strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            remain     <= '0;
            idx        <= '0;
            pkt_valid  <= 1'b0;
            pkt_count  <= '0;
            pkt_opcode <= '0;
        end else begin
            pkt_valid <= 1'b0;
            if (abort) begin
                busy   <= 1'b0;
                remain <= '0;
                idx    <= '0;
            end else if (in_valid) begin
                if (busy) begin
                    remain <= remain - 1'b1;
                    idx    <= idx + 1'b1;
                    if (remain == CNT_W'(1)) begin
                        busy      <= 1'b0;
                        pkt_valid <= 1'b1;
                        pkt_count <= CNT_W'(idx) + 1'b1;
                    end
                end else begin
                    pkt_opcode <= in_word[WORD_W-1 -: OP_W];
                    if (param_cnt == '0) begin
                        pkt_valid <= 1'b1;
                        pkt_count <= CNT_W'(1);
                    end else begin
                        busy   <= 1'b1;
                        remain <= param_cnt;
                        idx    <= IDX_W'(1);
                    end
                end
            end
        end
    end

    // One storage register per slot, flattened onto the output bus
    for (genvar g = 0; g < MAX_WORDS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(g))) slot[g] <= in_word;
        end
        assign pkt_words[g*WORD_W +: WORD_W] = slot[g];
    end
endmodule

// File: rtl/cmd_packet_assembler.sv
// Top level: groups data-port words into command packets.
// Assumes a single clock domain; control aborts act in the cycle they arrive.
module cmd_packet_assembler
    import cpa_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [WORD_W-1:0]           in_word,
    input  logic                        ctl_valid,
    input  logic [WORD_W-1:0]           ctl_word,
    output logic                        pkt_valid,
    output logic [OP_W-1:0]             pkt_opcode,
    output logic [CNT_W-1:0]            pkt_count,
    output logic [MAX_WORDS*WORD_W-1:0] pkt_words
);
    logic             abort;
    logic [CNT_W-1:0] param_cnt;

    cpa_ctl_decode u_ctl (
        .ctl_valid (ctl_valid),
        .ctl_word  (ctl_word),
        .abort     (abort)
    );

    cpa_len_lut u_lut (
        .opcode    (in_word[WORD_W-1 -: OP_W]),
        .param_cnt (param_cnt)
    );

    cpa_collector u_col (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_word    (in_word),
        .abort      (abort),
        .param_cnt  (param_cnt),
        .pkt_valid  (pkt_valid),
        .pkt_opcode (pkt_opcode),
        .pkt_count  (pkt_count),
        .pkt_words  (pkt_words)
    );
endmodule

// File: rtl/cpa_checker.sv
// Port-level temporal checks for cmd_packet_assembler, attached by bind.
module cpa_checker
    import cpa_pkg::*;
(
    input logic                        clk,
    input logic                        rst_n,
    input logic                        in_valid,
    input logic                        ctl_valid,
    input logic [WORD_W-1:0]           ctl_word,
    input logic                        pkt_valid,
    input logic [OP_W-1:0]             pkt_opcode,
    input logic [CNT_W-1:0]            pkt_count,
    input logic [MAX_WORDS*WORD_W-1:0] pkt_words
);
    logic abort_seen;
    assign abort_seen = ctl_valid &&
        ((ctl_word[31:24] == CTL_FULL_RESET) || (ctl_word[31:24] == CTL_CMD_RESET) ||
         (ctl_word == CTL_FLUSH_WORD));

    a_r5_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (pkt_count >= CNT_W'(1)) && (pkt_count <= CNT_W'(MAX_WORDS)));

    a_r5_opcode_word0: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (pkt_opcode == pkt_words[WORD_W-1 -: OP_W]));

    a_r6_strobe_follows_word: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> $past(in_valid));

    a_r10_abort_no_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
        abort_seen |=> !pkt_valid);

    a_r9_flush_no_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && ctl_word == CTL_FLUSH_WORD) |=> !pkt_valid);
endmodule

bind cmd_packet_assembler cpa_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .ctl_valid  (ctl_valid),
    .ctl_word   (ctl_word),
    .pkt_valid  (pkt_valid),
    .pkt_opcode (pkt_opcode),
    .pkt_count  (pkt_count),
    .pkt_words  (pkt_words)
);

// File: tb/cmd_packet_assembler_tb.sv
`timescale 1ns/1ps
module cmd_packet_assembler_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  in_word = '0;
    logic         ctl_valid = 1'b0;
    logic [31:0]  ctl_word = '0;
    logic         pkt_valid;
    logic [7:0]   pkt_opcode;
    logic [3:0]   pkt_count;
    logic [383:0] pkt_words;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [31:0] exp_w [12];

    always #2.5 clk = ~clk;

    cmd_packet_assembler u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .ctl_valid(ctl_valid), .ctl_word(ctl_word), .pkt_valid(pkt_valid),
        .pkt_opcode(pkt_opcode), .pkt_count(pkt_count), .pkt_words(pkt_words)
    );

    function automatic int exp_len(input int op);
        int g[8]  = '{3, 6, 4, 8, 5, 8, 7, 11};
        int h[16] = '{2, 0, 3, 3, 3, 0, 4, 4, 2, 3, 1, 2, 1, 2, 1, 2};
        if (op >= 32 && op < 64)  return g[(op - 32) / 4];
        if (op >= 64 && op < 128) return h[(op - 64) / 4];
        if (op == 2 || op == 160 || op == 192) return 2;
        if (op == 128) return 3;
        return 0;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive one cycle from a falling edge; return at the next falling edge
    task automatic step(input logic v, input logic [31:0] w,
                        input logic cv, input logic [31:0] cw);
        in_valid = v; in_word = w; ctl_valid = cv; ctl_word = cw;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; ctl_valid = 1'b0;
    endtask

    task automatic check_packet(input string req, input int op, input int n);
        chk(pkt_valid === 1'b1, req, "strobe", pkt_valid, 1);
        chk(pkt_count == 4'(n + 1), req, "count", pkt_count, n + 1);
        chk(pkt_opcode == 8'(op), req, "opcode", pkt_opcode, op);
        for (int k = 0; k <= n; k++)
            chk(pkt_words[k*32 +: 32] == exp_w[k], req, "word",
                pkt_words[k*32 +: 32], exp_w[k]);
    endtask

    // Send a full packet for op with n params, checking no early strobe
    task automatic send_packet(input string req, input int op, input int n);
        for (int k = 0; k <= n; k++) begin
            exp_w[k] = (k == 0) ? {8'(op), 8'h5A, 16'(op)}
                                : {8'(k), 8'(op), 16'hC3C3 ^ 16'(k)};
            step(1'b1, exp_w[k], 1'b0, '0);
            if (k < n) chk(pkt_valid === 1'b0, "R5", "early strobe", pkt_valid, 0);
        end
        check_packet(req, op, n);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(pkt_valid === 1'b0, "R1", "reset strobe", pkt_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pkt_valid === 1'b0, "R1", "after reset", pkt_valid, 0);

        // R2 R3 R4 R5 R6 R7: sweep all opcodes
        for (int op = 0; op < 256; op++) begin
            string req;
            req = (op >= 32 && op < 64) ? "R2" : (op >= 64 && op < 128) ? "R3" : "R4";
            send_packet(req, op, exp_len(op));
            step(1'b0, '0, 1'b0, '0);
            chk(pkt_valid === 1'b0, "R7", "strobe width", pkt_valid, 0);
        end

        // R8: command-buffer reset abandons a pending 0x28 packet
        step(1'b1, 32'h2800_0000, 1'b0, '0);
        step(1'b1, 32'h1111_1111, 1'b0, '0);
        step(1'b0, '0, 1'b1, 32'h0100_0000);
        chk(pkt_valid === 1'b0, "R8", "abort strobe", pkt_valid, 0);
        send_packet("R8", 2, 2);

        // R8: full reset abandons a pending 0x3C packet
        step(1'b1, 32'h3C00_0000, 1'b0, '0);
        step(1'b0, '0, 1'b1, 32'h00AB_CDEF);
        send_packet("R8", 128, 3);

        // R9: exact flush value aborts
        step(1'b1, 32'h2400_0000, 1'b0, '0);
        step(1'b1, 32'h2222_2222, 1'b0, '0);
        step(1'b0, '0, 1'b1, 32'h0400_0000);
        chk(pkt_valid === 1'b0, "R9", "flush strobe", pkt_valid, 0);
        send_packet("R9", 160, 2);

        // R9: near-flush value does not abort
        exp_w[0] = 32'h2000_0007;
        step(1'b1, exp_w[0], 1'b0, '0);
        exp_w[1] = 32'hAAAA_0001;
        step(1'b1, exp_w[1], 1'b0, '0);
        step(1'b0, '0, 1'b1, 32'h0400_0001);
        exp_w[2] = 32'hAAAA_0002;
        step(1'b1, exp_w[2], 1'b0, '0);
        chk(pkt_valid === 1'b0, "R9", "early strobe", pkt_valid, 0);
        exp_w[3] = 32'hAAAA_0003;
        step(1'b1, exp_w[3], 1'b0, '0);
        check_packet("R9", 32, 3);

        // R10: abort beside the final word drops it
        step(1'b1, 32'h2000_0000, 1'b0, '0);
        step(1'b1, 32'h3333_0001, 1'b0, '0);
        step(1'b1, 32'h3333_0002, 1'b0, '0);
        step(1'b1, 32'h3333_0003, 1'b1, 32'h0100_0000);
        chk(pkt_valid === 1'b0, "R10", "dropped word strobe", pkt_valid, 0);
        exp_w[0] = 32'h0000_0000;
        step(1'b1, exp_w[0], 1'b0, '0);
        check_packet("R10", 0, 0);

        // R11: idle gaps inside a 0x2C packet
        for (int k = 0; k <= 8; k++) begin
            exp_w[k] = {8'h2C, 8'(k), 16'hBEEF};
            step(1'b1, exp_w[k], 1'b0, '0);
            if (k < 8) begin
                step(1'b0, 32'hFFFF_FFFF, 1'b0, '0);
                chk(pkt_valid === 1'b0, "R11", "gap strobe", pkt_valid, 0);
            end
        end
        check_packet("R11", 8'h2C, 8);

        // R6: back-to-back zero-length opcodes give back-to-back strobes
        exp_w[0] = 32'h0300_0001;
        step(1'b1, exp_w[0], 1'b0, '0);
        check_packet("R6", 3, 0);
        exp_w[0] = 32'hFF00_0002;
        step(1'b1, exp_w[0], 1'b0, '0);
        check_packet("R6", 255, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule